// File: doc/BRIEF.md
# Write-Protected GPIO Pin-Function Controller

This block manages a parameterized number of 8-pin ports. Software reaches it over a small byte/halfword register bus. Each pin has the following state:

- a 2-bit direction field,
- an output-data bit,
- a synchronized input-data bit,
- a mode bit that hands the pin to a peripheral,
- a function-select byte.

The block drives the pad output-enable and output-value lines. It also gives an external peripheral mux each pin's function code, its interrupt-select flag and its peripheral-mode flag.

The function-select bytes are guarded by a protect register. Unlocking takes two steps. First, clear the write-disable bit (bit 7). Second, set the select-enable bit (bit 6), which can only be written while bit 7 was already 0 before the write. A select write attempted while locked changes nothing and raises a sticky error bit. Software can read that bit back and clear it.

A flat pin number `n` belongs to port `n / 8`, bit `n % 8`. Every pin-indexed output vector uses that flat numbering.

Top module: `pinfunc_ctrl`

## Requirements
- R1: After reset, the protect register reads 0x80, every direction field is 2'b00, and all mode, output-data and select bytes are 0. As a result, `pad_oe`, `pin_periph`, `pin_isel` and `pin_func` are all zero.
- R2: The register map is as follows:
  - Direction: a 16-bit word at 0x000 + port*2, two bits per pin at bit pin*2.
  - Output data: 0x040 + port.
  - Input data: 0x060 + port.
  - Mode: 0x080 + port.
  - Function select: 0x200 + port*8 + pin.
  - Protect register: 0x2FF.

  Read data is returned on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`. Byte reads are zero-extended.
- R3: `pad_oe` of a pin is high only when its mode bit is 0 and its direction field is 2'b11. `pad_out` of a pin equals its output-data bit.
- R4: A pin's input-data bit reads the pad value through a two-flop synchronizer when its direction field is 2'b10 (input) or 2'b11 (output). It reads 0 when the field is 2'b00 (unused). Writes to the input-data registers have no effect.
- R5: A write to the protect register always loads bit 7 (write disable). It loads bit 6 (select enable) only if bit 7 was 0 before that write; otherwise bit 6 keeps its value.
- R6: A function-select write takes effect only while protect bit 6 is 1. A select byte holds the interrupt-select flag in bit 6 and the function code in bits 5:0. Bit 7 is not stored and reads 0.
- R7: A function-select write made while protect bit 6 is 0 sets a sticky error flag, read as protect bit 0. Writing the protect register with bit 0 = 1 clears the flag.
- R8: A mode bit of 1 raises `pin_periph` for that pin and forces its `pad_oe` low. `pin_func` (6 bits per pin) and `pin_isel` present the stored select byte.
- R9: A byte write to a direction word changes only the addressed byte (address bit 0 picks the high byte). A halfword write replaces the whole word.
- R10: Accesses to ports or pins beyond the configured count read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 16 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_oe | output | NPINS | Pad output enable |
| pad_out | output | NPINS | Pad output value |
| pin_periph | output | NPINS | Pin handed to peripheral function |
| pin_isel | output | NPINS | Interrupt-select flag per pin |
| pin_func | output | NPINS*6 | Function code per pin, 6 bits each |

## Verification
Register writes land on the clock edge that samples the strobe, so `pad_oe`, `pad_out`, `pin_periph`, `pin_isel` and `pin_func` are checked at the falling edge right after the write cycle. Read data arrives one edge after the read strobe. The driver queues each expected read value when it raises the strobe, and the monitor pops and compares one entry at every falling edge where `bus_rvalid` is high. A pad change crosses two synchronizer flops before the read register captures it. The bench therefore waits two full cycles after changing `pad_in` before issuing the input-data read.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_DIR,
        REG_ODR,
        REG_IDR,
        REG_MODE,
        REG_FSEL,
        REG_PROT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
        logic       hi_lane;
    } reg_dec_t;

    localparam logic [11:0] A_DIR  = 12'h000;
    localparam logic [11:0] A_ODR  = 12'h040;
    localparam logic [11:0] A_IDR  = 12'h060;
    localparam logic [11:0] A_MODE = 12'h080;
    localparam logic [11:0] A_FSEL = 12'h200;
    localparam logic [11:0] A_PROT = 12'h2FF;

    function automatic reg_dec_t decode_addr(input logic [11:0] addr, input int nports);
        reg_dec_t d;
        int       off;
        d.kind    = REG_NONE;
        d.idx     = '0;
        d.hi_lane = addr[0];
        if (addr == A_PROT) begin
            d.kind = REG_PROT;
        end else if (addr >= A_FSEL && int'(addr - A_FSEL) < nports * 8) begin
            off    = int'(addr - A_FSEL);
            d.kind = REG_FSEL;
            d.idx  = 8'(off);
        end else if (addr < A_ODR && int'(addr[11:1]) < nports) begin
            d.kind = REG_DIR;
            d.idx  = 8'(addr[11:1]);
        end else if (addr >= A_ODR && addr < A_IDR && int'(addr - A_ODR) < nports) begin
            d.kind = REG_ODR;
            d.idx  = 8'(addr - A_ODR);
        end else if (addr >= A_IDR && addr < A_MODE && int'(addr - A_IDR) < nports) begin
            d.kind = REG_IDR;
            d.idx  = 8'(addr - A_IDR);
        end else if (addr >= A_MODE && int'(addr - A_MODE) < nports) begin
            d.kind = REG_MODE;
            d.idx  = 8'(addr - A_MODE);
        end
        return d;
    endfunction

endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign d_out = st_q.s2;
endmodule

// File: rtl/pfc_wprot.sv
module pfc_wprot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       sel_attempt,
    output logic       sel_open,
    output logic [7:0] rd_val
);
    typedef struct packed {
        logic wdis;
        logic sel_en;
        logic err;
    } prot_t;

    prot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.wdis = wdata[7];
            if (!st_q.wdis) st_d.sel_en = wdata[6];
            if (wdata[0])   st_d.err    = 1'b0;
        end
        if (sel_attempt && !st_q.sel_en) st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{wdis: 1'b1, sel_en: 1'b0, err: 1'b0};
        else        st_q <= st_d;
    end

    assign sel_open = st_q.sel_en;
    assign rd_val   = {st_q.wdis, st_q.sel_en, 5'b0, st_q.err};
endmodule

// File: rtl/pfc_pindrv.sv
module pfc_pindrv #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0][1:0] dir,
    input  logic [NPINS-1:0]      periph,
    input  logic [NPINS-1:0]      pad_sync,
    output logic [NPINS-1:0]      oe,
    output logic [NPINS-1:0]      in_bits
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign oe[p]      = !periph[p] && (dir[p] == 2'b11);
        assign in_bits[p] = dir[p][1] ? pad_sync[p] : 1'b0;
    end
endmodule

// File: rtl/pinfunc_ctrl.sv
module pinfunc_ctrl
    import pfc_pkg::*;
#(
    parameter int  NPORTS = 4,
    localparam int NPINS  = NPORTS * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_half,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    output logic               bus_rvalid,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pin_periph,
    output logic [NPINS-1:0]   pin_isel,
    output logic [NPINS*6-1:0] pin_func
);
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int NW = $clog2(NPINS);

    typedef struct packed {
        logic [NPORTS-1:0][15:0] dir;
        logic [NPORTS-1:0][7:0]  odr;
        logic [NPORTS-1:0][7:0]  mode;
        logic [NPINS-1:0][6:0]   fsel;
        logic [15:0]             rdata;
        logic                    rvalid;
    } regs_t;

    regs_t q, d;

    reg_dec_t                dec;
    logic                    sel_open;
    logic [7:0]              wp_rd;
    logic [NPINS-1:0]        pad_sync;
    logic [NPORTS-1:0][7:0]  idr;
    logic [PW-1:0]           pidx;
    logic [NW-1:0]           nidx;

    assign dec  = decode_addr(bus_addr, NPORTS);
    assign pidx = dec.idx[PW-1:0];
    assign nidx = dec.idx[NW-1:0];

    pfc_wprot u_wprot (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr && dec.kind == REG_PROT),
        .wdata       (bus_wdata[7:0]),
        .sel_attempt (bus_wr && dec.kind == REG_FSEL),
        .sel_open    (sel_open),
        .rd_val      (wp_rd)
    );

    pfc_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (pad_sync)
    );

    pfc_pindrv #(.NPINS(NPINS)) u_drv (
        .dir      (q.dir),
        .periph   (q.mode),
        .pad_sync (pad_sync),
        .oe       (pad_oe),
        .in_bits  (idr)
    );

    always_comb begin
        d        = q;
        d.rvalid = bus_rd;
        if (bus_wr) begin
            unique case (dec.kind)
                REG_DIR: begin
                    if (bus_half)        d.dir[pidx]       = bus_wdata;
                    else if (dec.hi_lane) d.dir[pidx][15:8] = bus_wdata[7:0];
                    else                  d.dir[pidx][7:0]  = bus_wdata[7:0];
                end
                REG_ODR:  d.odr[pidx]  = bus_wdata[7:0];
                REG_MODE: d.mode[pidx] = bus_wdata[7:0];
                REG_FSEL: if (sel_open) d.fsel[nidx] = bus_wdata[6:0];
                default: ;
            endcase
        end
        if (bus_rd) begin
            unique case (dec.kind)
                REG_DIR: begin
                    if (bus_half)         d.rdata = q.dir[pidx];
                    else if (dec.hi_lane) d.rdata = {8'h00, q.dir[pidx][15:8]};
                    else                  d.rdata = {8'h00, q.dir[pidx][7:0]};
                end
                REG_ODR:  d.rdata = {8'h00, q.odr[pidx]};
                REG_IDR:  d.rdata = {8'h00, idr[pidx]};
                REG_MODE: d.rdata = {8'h00, q.mode[pidx]};
                REG_FSEL: d.rdata = {9'h000, q.fsel[nidx]};
                REG_PROT: d.rdata = {8'h00, wp_rd};
                default:  d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata  = q.rdata;
    assign bus_rvalid = q.rvalid;
    assign pad_out    = q.odr;
    assign pin_periph = q.mode;

    for (genvar i = 0; i < NPINS; i++) begin : g_fn
        assign pin_func[i*6 +: 6] = q.fsel[i][5:0];
        assign pin_isel[i]        = q.fsel[i][6];
    end
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
    parameter int  NPORTS = 4,
    localparam int NPINS  = NPORTS * 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [11:0]        bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic               bus_rvalid,
    input logic [NPINS-1:0]   pad_oe,
    input logic [NPINS-1:0]   pin_periph,
    input logic [NPINS-1:0]   pin_isel,
    input logic [NPINS*6-1:0] pin_func,
    input logic [7:0]         wp_val
);
    logic sel_hit;
    logic prot_hit;
    assign sel_hit  = (bus_addr >= 12'h200) && (int'(bus_addr) < 'h200 + NPINS);
    assign prot_hit = (bus_addr == 12'h2FF);

    for (genvar i = 0; i < NPINS; i++) begin : g_oe
        assert_oe_gpio_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[i] |-> !pin_periph[i]);
    end

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    assert_enable_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && prot_hit && wp_val[7]) |=> (wp_val[6] == $past(wp_val[6])));

    assert_locked_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_val[6] |=> ($stable(pin_func) && $stable(pin_isel)));

    assert_sticky_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_hit && !wp_val[6]) |=> wp_val[0]);
endmodule

bind pinfunc_ctrl pfc_checker #(.NPORTS(NPORTS)) u_pfc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .pad_oe     (pad_oe),
    .pin_periph (pin_periph),
    .pin_isel   (pin_isel),
    .pin_func   (pin_func),
    .wp_val     (wp_rd)
);

// File: tb/test_pinfunc_ctrl.sv
module test_pinfunc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NPORTS     = 4;
    localparam int NPINS      = NPORTS * 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic               bus_half = 1'b0;
    logic [15:0]        bus_wdata = '0;
    logic [15:0]        bus_rdata;
    logic               bus_rvalid;
    logic [NPINS-1:0]   pad_in = '0;
    logic [NPINS-1:0]   pad_oe;
    logic [NPINS-1:0]   pad_out;
    logic [NPINS-1:0]   pin_periph;
    logic [NPINS-1:0]   pin_isel;
    logic [NPINS*6-1:0] pin_func;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pinfunc_ctrl #(.NPORTS(NPORTS)) i_pinfunc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_half(bus_half), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pin_periph(pin_periph),
        .pin_isel(pin_isel), .pin_func(pin_func)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [11:0] a, input logic [15:0] v, input logic h);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_half = h; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [11:0] a, input logic h, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_half = h; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: compares each returned read with the queued expectation
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2 unexpected read data actual=%0h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pad_oe", 64'(pad_oe), 64'h0);
        chk("R1 pin_periph", 64'(pin_periph), 64'h0);
        chk("R1 pin_func", 64'(pin_func), 64'h0);
        brd(12'h2FF, 1'b0, 16'h0080, "R1 protect reset");
        brd(12'h002, 1'b1, 16'h0000, "R1 dir reset");
        brd(12'h209, 1'b0, 16'h0000, "R1 select reset");

        // R3 port1: pin0 input (10), pin1 output (11)
        bwr(12'h002, 16'h000E, 1'b1);
        bwr(12'h041, 16'h00FF, 1'b0);
        chk("R3 pad_oe only pin9", 64'(pad_oe), 64'h0000_0200);
        chk("R3 pad_out follows odr", 64'(pad_out), 64'h0000_FF00);
        brd(12'h002, 1'b1, 16'h000E, "R2 dir word");
        brd(12'h041, 1'b0, 16'h00FF, "R2 odr byte");

        // R8 mode bit hands pin9 to peripheral
        bwr(12'h081, 16'h0002, 1'b0);
        chk("R8 oe dropped in periph mode", 64'(pad_oe), 64'h0);
        chk("R8 pin_periph", 64'(pin_periph), 64'h0000_0200);
        brd(12'h081, 1'b0, 16'h0002, "R2 mode byte");

        // R6/R7 locked select write
        bwr(12'h209, 16'h0047, 1'b0);
        brd(12'h209, 1'b0, 16'h0000, "R6 locked write ignored");
        brd(12'h2FF, 1'b0, 16'h0081, "R7 error set");
        chk("R6 pin_func unchanged", 64'(pin_func), 64'h0);

        // R5 enable ignored while write-disable is set
        bwr(12'h2FF, 16'h0040, 1'b0);
        brd(12'h2FF, 1'b0, 16'h0001, "R5 enable ignored");
        bwr(12'h2FF, 16'h0040, 1'b0);
        brd(12'h2FF, 1'b0, 16'h0041, "R5 second step unlocks");

        // R6 open write, bit 7 dropped
        bwr(12'h209, 16'h00C7, 1'b0);
        brd(12'h209, 1'b0, 16'h0047, "R6 stored select");
        chk("R8 pin_func pin9", 64'(pin_func[9*6 +: 6]), 64'h7);
        chk("R8 pin_isel", 64'(pin_isel), 64'h0000_0200);

        // R7 clear, then relock
        bwr(12'h2FF, 16'h0041, 1'b0);
        brd(12'h2FF, 1'b0, 16'h0040, "R7 error cleared");
        bwr(12'h2FF, 16'h0000, 1'b0);
        bwr(12'h2FF, 16'h0080, 1'b0);
        brd(12'h2FF, 1'b0, 16'h0080, "R5 relocked");
        bwr(12'h209, 16'h0015, 1'b0);
        brd(12'h209, 1'b0, 16'h0047, "R6 relocked write ignored");
        brd(12'h2FF, 1'b0, 16'h0081, "R7 error again");
        bwr(12'h2FF, 16'h0081, 1'b0);
        brd(12'h2FF, 1'b0, 16'h0080, "R7 cleared while locked");

        // R4 input sampling
        pad_in = '1;
        repeat (2) @(negedge clk);
        brd(12'h061, 1'b0, 16'h0003, "R4 sync input port1");
        brd(12'h060, 1'b0, 16'h0000, "R4 unused dir reads 0");
        bwr(12'h061, 16'h0000, 1'b0);
        brd(12'h061, 1'b0, 16'h0003, "R4 idr write ignored");

        // R9 byte lane write of direction
        bwr(12'h003, 16'h00C0, 1'b0);
        brd(12'h002, 1'b1, 16'hC00E, "R9 high lane only");
        brd(12'h003, 1'b0, 16'h00C0, "R9 high byte read");
        brd(12'h002, 1'b0, 16'h000E, "R9 low byte read");
        chk("R3 pad_oe pin15", 64'(pad_oe), 64'h0000_8000);

        // R10 unmapped
        bwr(12'h044, 16'h00FF, 1'b0);
        chk("R10 pad_out unchanged", 64'(pad_out), 64'h0000_FF00);
        brd(12'h044, 1'b0, 16'h0000, "R10 unmapped odr");
        brd(12'h008, 1'b1, 16'h0000, "R10 unmapped dir");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule